// File: doc/BRIEF.md
# Universal Registered Bus Transceiver

This block links two parallel data ports, A and B, one path for each direction. Each path has a single storage element per bit. That element can pass its input straight to the far port, hold the last value it took, or load a new value when its direction clock falls. Each path has four controls of its own:

- an active-low drive enable,
- a pass-through (latch) enable,
- a direction clock,
- an active-low clock gate.

Three-state pins are modelled as a drive value plus a drive-enable flag, so the logic stays synthesizable. Each port also has a bus keeper. When nothing drives a port, the keeper supplies the last value that was present on that port.

The whole block runs on one system clock. The direction clocks and the other controls are treated as slow signals sampled on that clock. A falling edge of a direction clock is found by comparing its present level with the level registered on the previous system clock. The pass-through path is combinational from the port value to the far side. A flag reports when both drive enables are active together.

Top module: `univ_bus_xcvr`

## Requirements
- R1: While a path's pass-through enable is high, the far-side drive value equals the near-side port value in the same cycle, and the storage takes that value at the next system clock.
- R2: While the pass-through enable is low and no enabled falling edge of the direction clock occurs, the stored value and the far-side drive value do not change, even when the near-side data changes.
- R3: With the pass-through enable low and the clock gate low, a direction clock that was high at the previous system clock and is low now loads the near-side value present in that cycle. The new value appears on the far side from the following cycle.
- R4: While the clock gate input is high, falling edges of the direction clock leave the stored value unchanged.
- R5: A path's drive-enable flag on the far port is high exactly when that path's active-low drive enable input is low. The drive value is present whether or not the flag is set.
- R6: The B-to-A path obeys R1 to R4 with its own four controls, independently of the A-to-B path.
- R7: When a port has no external driver and the block is not driving it, the value fed into the path that reads that port is the last value present on the port. This includes a value the block itself drove there.
- R8: The conflict flag is high exactly when both active-low drive enables are low, and both ports keep driving in that case.
- R9: While the synchronous active-low reset is low at a system clock edge, both stores, both keepers and both edge detectors clear to zero.
- R10: A rising edge of a direction clock never loads new data while the pass-through enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| a_in | input | WIDTH | Value driven onto port A from outside |
| a_in_drv | input | 1 | High when an external driver is active on port A |
| b_in | input | WIDTH | Value driven onto port B from outside |
| b_in_drv | input | 1 | High when an external driver is active on port B |
| oe_ab_n | input | 1 | Active-low drive enable for port B (A-to-B path) |
| le_ab | input | 1 | Pass-through enable, A-to-B path |
| clk_ab | input | 1 | Direction clock, A-to-B path, loads on falling edge |
| cken_ab_n | input | 1 | Active-low clock gate, A-to-B path |
| oe_ba_n | input | 1 | Active-low drive enable for port A (B-to-A path) |
| le_ba | input | 1 | Pass-through enable, B-to-A path |
| clk_ba | input | 1 | Direction clock, B-to-A path, loads on falling edge |
| cken_ba_n | input | 1 | Active-low clock gate, B-to-A path |
| a_out | output | WIDTH | Drive value for port A |
| a_oe | output | 1 | Drive enable for port A |
| b_out | output | WIDTH | Drive value for port B |
| b_oe | output | 1 | Drive enable for port B |
| bus_conflict | output | 1 | Both directions are driving at once |

## Verification
The bench builds the block with its default 18-bit width. Alternating and walking bit patterns therefore reach both the top bit and the bottom bit of every lane, so a stuck or swapped bit in either path shows up. A behavioural model compares every output on every cycle. It covers the sequences that separate the modes: pass-through followed by a hold, a rising edge followed by a falling edge, a gated edge, and a port released right after the block itself drove it.

// File: rtl/xcvr_pkg.sv
// Shared types for the universal bus transceiver.
// Assumes: nothing beyond the IEEE 1800-2017 language.
package xcvr_pkg;

    // Control set of one transfer direction, as sampled from its pins.
    typedef struct packed {
        logic oe_n;    // active-low drive enable of the far port
        logic le;      // pass-through enable
        logic dclk;    // direction clock, loads on falling edge
        logic cken_n;  // active-low clock gate
    } dir_ctrl_t;

endpackage

// File: rtl/xcvr_edge.sv
// Falling-edge load detector for one direction.
// It registers the direction clock on the system clock. It raises load_o in
// a cycle where the registered level is high, the present level is low, the
// clock gate is low and the pass-through enable is low.
// Assumes: the direction clock is slow next to clk (at least one clk period
// per level).
module xcvr_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic dclk_i,
    input  logic cken_n_i,
    input  logic le_i,
    output logic load_o
);

    logic dclk_q;

    // Remember the direction clock level from the previous system clock.
    always_ff @(posedge clk) begin
        if (!rst_n) dclk_q <= 1'b0;
        else        dclk_q <= dclk_i;
    end

    // Gated high-to-low change while the pass-through enable is off.
    always_comb begin
        load_o = dclk_q && !dclk_i && !cken_n_i && !le_i;
    end

    AST_LOAD_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |-> ($past(dclk_i) && !dclk_i)); // R3

endmodule

// File: rtl/xcvr_store.sv
// Per-bit storage for one direction, repeated WIDTH times.
// While le_i is high each bit follows d_i and q_o passes d_i straight
// through. Otherwise a bit loads d_i only when load_i is high.
// Assumes: load_i is never high while le_i is high.
module xcvr_store #(
    parameter int WIDTH = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    input  logic             le_i,
    input  logic             load_i,
    output logic [WIDTH-1:0] q_o,
    output logic [WIDTH-1:0] held_o
);

    logic [WIDTH-1:0] held;

    for (genvar gi = 0; gi < WIDTH; gi++) begin : g_bit
        // One storage bit: follows in pass-through, loads on a gated edge.
        always_ff @(posedge clk) begin
            if (!rst_n)               held[gi] <= 1'b0;
            else if (le_i || load_i)  held[gi] <= d_i[gi];
        end

        // Output bit: pass-through value or the stored value.
        always_comb begin
            q_o[gi] = le_i ? d_i[gi] : held[gi];
        end
    end

    assign held_o = held;

    AST_PASS_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        le_i |=> (held == $past(d_i))); // R1
    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!le_i && !load_i) |=> (held == $past(held))); // R2
    AST_EDGE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (held == $past(d_i))); // R3

endmodule

// File: rtl/xcvr_keeper.sv
// Bus keeper for one port.
// It records the value present on the port: the block's own drive when that
// drive is enabled, else the external value when an external driver is
// active. The data fed to the reading path is the external value when one is
// driven, else the recorded value.
// Assumes: own drive takes priority over an external driver on the record.
module xcvr_keeper #(
    parameter int WIDTH = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] ext_val_i,
    input  logic             ext_drv_i,
    input  logic [WIDTH-1:0] own_val_i,
    input  logic             own_oe_i,
    output logic [WIDTH-1:0] src_o
);

    logic [WIDTH-1:0] kept;

    // Record the last value present on the port.
    always_ff @(posedge clk) begin
        if (!rst_n)         kept <= '0;
        else if (own_oe_i)  kept <= own_val_i;
        else if (ext_drv_i) kept <= ext_val_i;
    end

    // Data seen by the reading path.
    always_comb begin
        src_o = ext_drv_i ? ext_val_i : kept;
    end

    AST_KEEP_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_drv_i && !own_oe_i) |=> (kept == $past(kept))); // R7
    AST_KEEP_OWN: assert property (@(posedge clk) disable iff (!rst_n)
        own_oe_i |=> (kept == $past(own_val_i))); // R7

endmodule

// File: rtl/univ_bus_xcvr.sv
// Universal registered bus transceiver between ports A and B.
// Each direction has a keeper on its source port, a falling-edge detector
// and a storage lane that can pass data through, hold it, or load it. The
// drive outputs carry a value plus an enable that stands in for three-state.
// Assumes: all control inputs are synchronous to clk or slow next to it.
module univ_bus_xcvr #(
    parameter int WIDTH = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] a_in,
    input  logic             a_in_drv,
    input  logic [WIDTH-1:0] b_in,
    input  logic             b_in_drv,
    input  logic             oe_ab_n,
    input  logic             le_ab,
    input  logic             clk_ab,
    input  logic             cken_ab_n,
    input  logic             oe_ba_n,
    input  logic             le_ba,
    input  logic             clk_ba,
    input  logic             cken_ba_n,
    output logic [WIDTH-1:0] a_out,
    output logic             a_oe,
    output logic [WIDTH-1:0] b_out,
    output logic             b_oe,
    output logic             bus_conflict
);

    import xcvr_pkg::*;

    localparam int NDIR = 2;  // index 0: A to B, index 1: B to A

    dir_ctrl_t        ctrl     [NDIR];
    logic [WIDTH-1:0] src      [NDIR];
    logic [WIDTH-1:0] far_val  [NDIR];
    logic [WIDTH-1:0] held     [NDIR];
    logic [WIDTH-1:0] ext_val  [NDIR];
    logic             ext_drv  [NDIR];
    logic             load     [NDIR];
    logic             far_oe   [NDIR];

    // Bundle the pin controls of each direction.
    always_comb begin
        ctrl[0]    = '{oe_n: oe_ab_n, le: le_ab, dclk: clk_ab, cken_n: cken_ab_n};
        ctrl[1]    = '{oe_n: oe_ba_n, le: le_ba, dclk: clk_ba, cken_n: cken_ba_n};
        ext_val[0] = a_in;
        ext_drv[0] = a_in_drv;
        ext_val[1] = b_in;
        ext_drv[1] = b_in_drv;
    end

    for (genvar gd = 0; gd < NDIR; gd++) begin : g_dir
        // Drive enable of the far port for this direction.
        always_comb begin
            far_oe[gd] = !ctrl[gd].oe_n;
        end

        // Keeper on the source port. The block drives that port through
        // the opposite direction.
        xcvr_keeper #(.WIDTH(WIDTH)) i_keeper (
            .clk       (clk),
            .rst_n     (rst_n),
            .ext_val_i (ext_val[gd]),
            .ext_drv_i (ext_drv[gd]),
            .own_val_i (far_val[NDIR-1-gd]),
            .own_oe_i  (far_oe[NDIR-1-gd]),
            .src_o     (src[gd])
        );

        xcvr_edge i_edge (
            .clk      (clk),
            .rst_n    (rst_n),
            .dclk_i   (ctrl[gd].dclk),
            .cken_n_i (ctrl[gd].cken_n),
            .le_i     (ctrl[gd].le),
            .load_o   (load[gd])
        );

        xcvr_store #(.WIDTH(WIDTH)) i_store (
            .clk    (clk),
            .rst_n  (rst_n),
            .d_i    (src[gd]),
            .le_i   (ctrl[gd].le),
            .load_i (load[gd]),
            .q_o    (far_val[gd]),
            .held_o (held[gd])
        );
    end

    // Map the lanes onto the port outputs and flag double drive.
    always_comb begin
        b_out        = far_val[0];
        b_oe         = far_oe[0];
        a_out        = far_val[1];
        a_oe         = far_oe[1];
        bus_conflict = far_oe[0] && far_oe[1];
    end

    AST_GATE_AB: assert property (@(posedge clk) disable iff (!rst_n)
        (!le_ab && cken_ab_n) |=> (held[0] == $past(held[0]))); // R4
    AST_GATE_BA: assert property (@(posedge clk) disable iff (!rst_n)
        (!le_ba && cken_ba_n) |=> (held[1] == $past(held[1]))); // R6
    AST_RISE_IGNORED_AB: assert property (@(posedge clk) disable iff (!rst_n)
        (!le_ab && clk_ab) |=> (held[0] == $past(held[0]))); // R10
    AST_RISE_IGNORED_BA: assert property (@(posedge clk) disable iff (!rst_n)
        (!le_ba && clk_ba) |=> (held[1] == $past(held[1]))); // R10
    AST_CONFLICT_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        bus_conflict |-> (!oe_ab_n && !oe_ba_n)); // R8
    AST_PASS_B: assert property (@(posedge clk) disable iff (!rst_n)
        (le_ab && a_in_drv) |-> (b_out == a_in)); // R1

endmodule

// File: tb/test_univ_bus_xcvr.sv
// Self-checking bench with a behavioural reference model checked every cycle.
module test_univ_bus_xcvr;

    localparam int W = 18;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic         a_in_drv = 1'b0, b_in_drv = 1'b0;
    logic         oe_ab_n = 1'b1, le_ab = 1'b0, clk_ab = 1'b0, cken_ab_n = 1'b1;
    logic         oe_ba_n = 1'b1, le_ba = 1'b0, clk_ba = 1'b0, cken_ba_n = 1'b1;
    logic [W-1:0] a_out, b_out;
    logic         a_oe, b_oe, bus_conflict;

    int    n_tests = 0;
    int    n_fail  = 0;
    string cur_req = "R9";

    // Reference state.
    logic [W-1:0] m_st_ab = '0, m_st_ba = '0, m_kp_a = '0, m_kp_b = '0;
    logic         m_pv_ab = 1'b0, m_pv_ba = 1'b0;

    univ_bus_xcvr #(.WIDTH(W)) i_univ_bus_xcvr (
        .clk(clk), .rst_n(rst_n),
        .a_in(a_in), .a_in_drv(a_in_drv), .b_in(b_in), .b_in_drv(b_in_drv),
        .oe_ab_n(oe_ab_n), .le_ab(le_ab), .clk_ab(clk_ab), .cken_ab_n(cken_ab_n),
        .oe_ba_n(oe_ba_n), .le_ba(le_ba), .clk_ba(clk_ba), .cken_ba_n(cken_ba_n),
        .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe),
        .bus_conflict(bus_conflict)
    );

    always #4 clk = ~clk;

    task automatic check(input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
        end
    endtask

    // One cycle: compare outputs mid-cycle, then advance the model at the edge.
    task automatic step();
        logic [W-1:0] asrc, bsrc, eb, ea;
        @(negedge clk); #1;
        asrc = a_in_drv ? a_in : m_kp_a;
        bsrc = b_in_drv ? b_in : m_kp_b;
        eb = le_ab ? asrc : m_st_ab;
        ea = le_ba ? bsrc : m_st_ba;
        check("b_out", b_out, eb);
        check("a_out", a_out, ea);
        check("b_oe", W'(b_oe), W'(!oe_ab_n));
        check("a_oe", W'(a_oe), W'(!oe_ba_n));
        check("bus_conflict", W'(bus_conflict), W'(!oe_ab_n && !oe_ba_n));
        @(posedge clk);
        if (!rst_n) begin
            m_st_ab = '0; m_st_ba = '0; m_kp_a = '0; m_kp_b = '0;
            m_pv_ab = 1'b0; m_pv_ba = 1'b0;
        end else begin
            if (le_ab || (m_pv_ab && !clk_ab && !cken_ab_n)) m_st_ab = asrc;
            if (le_ba || (m_pv_ba && !clk_ba && !cken_ba_n)) m_st_ba = bsrc;
            m_pv_ab = clk_ab;
            m_pv_ba = clk_ba;
            if (!oe_ba_n)      m_kp_a = ea;
            else if (a_in_drv) m_kp_a = a_in;
            if (!oe_ab_n)      m_kp_b = eb;
            else if (b_in_drv) m_kp_b = b_in;
        end
        #1;
    endtask

    initial begin : watchdog
        #(8 * 20000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        @(posedge clk); #1;
        // R9: reset state, with data driven that must not leak into storage.
        cur_req = "R9";
        a_in = 18'h3FFFF; a_in_drv = 1'b1; clk_ab = 1'b1; cken_ab_n = 1'b0;
        step(); clk_ab = 1'b0; step();
        check("b_out after reset", b_out, '0);
        rst_n = 1'b1;
        clk_ab = 1'b0; cken_ab_n = 1'b1;

        // R1: pass-through with several patterns.
        cur_req = "R1";
        le_ab = 1'b1;
        foreach (a_in[k]) begin
            a_in = W'(1) << k; step();
        end
        a_in = 18'h2AAAA; step();
        a_in = 18'h15555; step();

        // R2: hold after the pass-through enable drops.
        cur_req = "R2";
        le_ab = 1'b0;
        a_in = 18'h00F0F; step(); step();
        check("held pattern", b_out, 18'h15555);
        clk_ab = 1'b1; step(); step();

        // R3: gated falling edge loads.
        cur_req = "R3";
        cken_ab_n = 1'b0; a_in = 18'h3C3C3;
        clk_ab = 1'b0; step(); step();
        check("after fall", b_out, 18'h3C3C3);

        // R10: rising edge must not load.
        cur_req = "R10";
        a_in = 18'h12345; clk_ab = 1'b1; step(); step();
        check("after rise", b_out, 18'h3C3C3);
        clk_ab = 1'b0; step();

        // R4: clock gate high blocks a falling edge.
        cur_req = "R4";
        cken_ab_n = 1'b1; clk_ab = 1'b1; step();
        a_in = 18'h0BEEF; clk_ab = 1'b0; step(); step();
        check("gated edge", b_out, 18'h12345);

        // R5: drive enable flag follows the active-low input.
        cur_req = "R5";
        oe_ab_n = 1'b0; step();
        oe_ab_n = 1'b1; step();

        // R6: the B-to-A path, independent of A-to-B.
        cur_req = "R6";
        b_in_drv = 1'b1; le_ba = 1'b1; b_in = 18'h1F00F; step();
        b_in = 18'h20FF0; step();
        le_ba = 1'b0; b_in = 18'h00001; step();
        cken_ba_n = 1'b0; clk_ba = 1'b1; step();
        clk_ba = 1'b0; step(); step();
        check("ba load", a_out, 18'h00001);
        check("ab untouched", b_out, 18'h12345);

        // R7: keeper holds the last external value, then the block's own drive.
        cur_req = "R7";
        le_ab = 1'b1; a_in = 18'h2A5A5; step();
        a_in_drv = 1'b0; a_in = 18'h3FFFF; step(); step();
        check("kept external", b_out, 18'h2A5A5);
        oe_ba_n = 1'b0; step();
        oe_ba_n = 1'b1; step(); step();
        check("kept own drive", b_out, 18'h00001);

        // R8: both directions drive together.
        cur_req = "R8";
        oe_ab_n = 1'b0; oe_ba_n = 1'b0; step();
        check("conflict", W'(bus_conflict), W'(1));
        oe_ba_n = 1'b1; step();
        oe_ab_n = 1'b1; step();

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule